// File: doc/BRIEF.md
# Parallel NOR Flash Byte Program Sequencer

This block drives a byte-wide parallel NOR flash with a 22-bit address bus. A requester pulses `start` with `op_prog` selecting the operation. A read fetches one byte and returns it on `rd_data`. A program writes three unlock bus cycles and then the target byte. It then reads the target address repeatedly until the device reports that the write has finished or failed.

Each bus cycle is timed in clock cycles. On a write, chip enable and write enable stay low for `WR_HOLD` cycles while output enable stays high and the block drives the data lines. On a read, chip enable and output enable stay low for `RD_WAIT` cycles with the data lines released, and the byte is captured at the end of that window. Chip enable returns high after every bus cycle. The polling stops on either of two conditions. The first is that bit 7 of the polled byte matches bit 7 of the written byte. The second is that bit 5 is set while bit 7 still differs. A cycle counter also ends polling that runs past `POLL_LIMIT` cycles. Both failure paths write the reset command F0 before they report.

Top module: `pflash_prog_seq`

## Requirements
- R1: After reset `flash_ce_n`, `flash_oe_n` and `flash_we_n` are high, `flash_dq_oe` is low, and `busy`, `done`, `ok` and `fail` are low.
- R2: A read operation (`op_prog`=0) produces one bus cycle with chip enable and output enable low for `RD_WAIT` cycles. During it `flash_we_n` is high and `flash_dq_oe` is low. The byte on `flash_dq_in` at the end of that cycle appears on `rd_data` when `done` pulses with `ok`.
- R3: Every bus write holds `flash_ce_n` and `flash_we_n` low for exactly `WR_HOLD` cycles, with `flash_oe_n` high and `flash_dq_oe` high.
- R4: A program operation (`op_prog`=1) begins with these writes in this order: 0xAA to address 0x000AAA, 0x55 to 0x000555, 0xA0 to 0x000AAA, then the requested byte to the requested address.
- R5: After the data write, the block reads the requested address repeatedly. When a read returns bit 7 equal to bit 7 of the written byte, the block ends with `done` and `ok` and makes no further bus cycle.
- R6: When a polled byte has bit 7 different from the written bit 7 and bit 5 set, the block writes 0xF0 to the target address and then ends with `done` and `fail`.
- R7: When polling has run for `POLL_LIMIT` cycles without success, the block writes 0xF0 and ends with `done` and `fail`.
- R8: `busy` is high from the cycle after `start` is accepted up to and including the cycle of `done`, and is low in the cycle after. `done` lasts one cycle, and exactly one of `ok` or `fail` is high with it.
- R9: A `start` pulse while `busy` is high is ignored: it causes no extra bus cycle and no extra `done`.
- R10: `flash_rst_n` and `flash_wp_n` are held high at all times.
- R11: Chip enable goes high between any two bus cycles, so that every bus cycle has its own falling edge of `flash_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| op_prog | input | 1 | 1 selects program, 0 selects read |
| req_addr | input | 22 | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success, valid with done |
| fail | output | 1 | Failure, valid with done |
| rd_data | output | 8 | Byte returned by a read operation |
| flash_addr | output | 22 | Flash address lines |
| flash_dq_out | output | 8 | Data driven to the flash |
| flash_dq_oe | output | 1 | Drive enable for the data lines |
| flash_dq_in | input | 8 | Data read from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_rst_n | output | 1 | Flash reset pin, held high |
| flash_wp_n | output | 1 | Write-protect pin, held high |

## Verification
Two pairs of events can land together. The first pair is a new `start` and an operation in progress. The bench pulses a read request in the middle of a program and then counts bus cycles and `done` pulses. The second pair is a completed poll read and the watchdog limit on the same read. The bench makes the device model reply "busy" forever, with bit 5 clear, and expects exactly one 0xF0 write followed by a single `fail`. The bit-5 failure is tested on the first poll, and the bench checks that the reset write follows directly after that poll.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {BC_IDLE, BC_ACT, BC_REC} bc_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_state_t;
  typedef enum logic [2:0] {
    PH_UNLK1, PH_UNLK2, PH_CMD, PH_DATA, PH_POLL, PH_RESET, PH_READ
  } phase_t;

  parameter logic [7:0]  CMD_UNLK1 = 8'hAA;
  parameter logic [7:0]  CMD_UNLK2 = 8'h55;
  parameter logic [7:0]  CMD_PROG  = 8'hA0;
  parameter logic [7:0]  CMD_RESET = 8'hF0;
  parameter logic [21:0] ADR_UNLK1 = 22'h000AAA;
  parameter logic [21:0] ADR_UNLK2 = 22'h000555;
endpackage

// File: rtl/pfs_bus_cycle.sv
module pfs_bus_cycle
  import pfs_pkg::*;
#(
  parameter int AW      = 22,
  parameter int DW      = 8,
  parameter int WR_HOLD = 6,
  parameter int RD_WAIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          cyc_done,
  output logic [DW-1:0] cyc_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n
);
  localparam int MAXW = (WR_HOLD > RD_WAIT) ? WR_HOLD : RD_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  bc_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] rdat_q, rdat_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    data_d = data_q;
    rdat_d = rdat_q;
    case (st_q)
      BC_IDLE: if (go) begin
        st_d   = BC_ACT;
        wr_d   = go_wr;
        addr_d = go_addr;
        data_d = go_data;
        cnt_d  = go_wr ? CW'(WR_HOLD - 1) : CW'(RD_WAIT - 1);
      end
      BC_ACT: begin
        if (cnt_q == '0) begin
          st_d = BC_REC;
          if (!wr_q) rdat_d = bus_din;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BC_REC:  st_d = BC_IDLE;
      default: st_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BC_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
      rdat_q <= rdat_d;
    end
  end

  assign ce_n      = (st_q != BC_ACT);
  assign we_n      = !((st_q == BC_ACT) && wr_q);
  assign oe_n      = !((st_q == BC_ACT) && !wr_q);
  assign bus_oe    = wr_q && (st_q != BC_IDLE);
  assign bus_addr  = addr_q;
  assign bus_dout  = data_q;
  assign cyc_done  = (st_q == BC_REC);
  assign cyc_rdata = rdat_q;

  // checker: length of the current write-enable low run
  logic [CW:0] wlow_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wlow_q <= '0;
    else if (!we_n) wlow_q <= wlow_q + 1'b1;
    else            wlow_q <= '0;
  end

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (wlow_q == (CW+1)'(WR_HOLD)));
  // R3
  wr_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && bus_oe && !ce_n));
  // R2
  rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !bus_oe));
  // R11
  ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> ce_n);
endmodule

// File: rtl/pfs_poll_timer.sv
module pfs_poll_timer #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                           cnt_d = '0;
    else if (en && (cnt_q != TW'(LIMIT))) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/pflash_prog_seq.sv
module pflash_prog_seq
  import pfs_pkg::*;
#(
  parameter int AW         = 22,
  parameter int DW         = 8,
  parameter int WR_HOLD    = 6,
  parameter int RD_WAIT    = 5,
  parameter int POLL_LIMIT = 50000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_prog,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          fail,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] flash_addr,
  output logic [DW-1:0] flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [DW-1:0] flash_dq_in,
  output logic          flash_ce_n,
  output logic          flash_oe_n,
  output logic          flash_we_n,
  output logic          flash_rst_n,
  output logic          flash_wp_n
);
  localparam int POLL_BIT = DW - 1;
  localparam int ERR_BIT  = DW - 3;

  sq_state_t     st_q, st_d;
  phase_t        ph_q, ph_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          res_q, res_d;

  logic          go, go_wr, cyc_done, tmr_clr, tmr_en, tmr_exp;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_data, cyc_rdata;

  always_comb begin
    go_addr = addr_q;
    go_data = data_q;
    case (ph_q)
      PH_UNLK1: begin go_addr = ADR_UNLK1; go_data = CMD_UNLK1; end
      PH_UNLK2: begin go_addr = ADR_UNLK2; go_data = CMD_UNLK2; end
      PH_CMD:   begin go_addr = ADR_UNLK1; go_data = CMD_PROG;  end
      PH_RESET: go_data = CMD_RESET;
      default:  ;
    endcase
  end

  assign go    = (st_q == SQ_ISSUE);
  assign go_wr = (ph_q != PH_POLL) && (ph_q != PH_READ);

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    addr_d = addr_q;
    data_d = data_q;
    rd_d  = rd_q;
    res_d = res_q;
    case (st_q)
      SQ_IDLE: if (start) begin
        addr_d = req_addr;
        data_d = req_data;
        ph_d   = op_prog ? PH_UNLK1 : PH_READ;
        st_d   = SQ_ISSUE;
      end
      SQ_ISSUE: st_d = SQ_WAIT;
      SQ_WAIT: if (cyc_done) begin
        st_d = SQ_ISSUE;
        case (ph_q)
          PH_UNLK1: ph_d = PH_UNLK2;
          PH_UNLK2: ph_d = PH_CMD;
          PH_CMD:   ph_d = PH_DATA;
          PH_DATA:  ph_d = PH_POLL;
          PH_POLL: begin
            if (cyc_rdata[POLL_BIT] == data_q[POLL_BIT]) begin
              res_d = 1'b1;
              st_d  = SQ_DONE;
            end else if (cyc_rdata[ERR_BIT] || tmr_exp) begin
              ph_d = PH_RESET;
            end
          end
          PH_RESET: begin
            res_d = 1'b0;
            st_d  = SQ_DONE;
          end
          default: begin
            rd_d  = cyc_rdata;
            res_d = 1'b1;
            st_d  = SQ_DONE;
          end
        endcase
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ph_q   <= PH_READ;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      res_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      addr_q <= addr_d;
      data_q <= data_d;
      rd_q   <= rd_d;
      res_q  <= res_d;
    end
  end

  assign tmr_clr = (st_q == SQ_WAIT) && cyc_done && (ph_q == PH_DATA);
  assign tmr_en  = (ph_q == PH_POLL);

  pfs_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .expired(tmr_exp)
  );

  pfs_bus_cycle #(.AW(AW), .DW(DW), .WR_HOLD(WR_HOLD), .RD_WAIT(RD_WAIT)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_wr(go_wr), .go_addr(go_addr), .go_data(go_data),
    .cyc_done(cyc_done), .cyc_rdata(cyc_rdata),
    .bus_addr(flash_addr), .bus_dout(flash_dq_out), .bus_oe(flash_dq_oe),
    .bus_din(flash_dq_in),
    .ce_n(flash_ce_n), .oe_n(flash_oe_n), .we_n(flash_we_n)
  );

  assign busy        = (st_q != SQ_IDLE);
  assign done        = (st_q == SQ_DONE);
  assign ok          = done && res_q;
  assign fail        = done && !res_q;
  assign rd_data     = rd_q;
  assign flash_rst_n = 1'b1;
  assign flash_wp_n  = 1'b1;

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != fail));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8
  bus_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_ce_n |-> busy);
endmodule

// File: tb/sim_pflash_prog_seq.sv
`timescale 1ns/1ps
module sim_pflash_prog_seq;
  localparam int WRH = 6;
  localparam int RDW = 5;
  localparam int PLIM = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_prog = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        busy, done, ok, fail;
  logic [7:0]  rd_data;
  logic [21:0] flash_addr;
  logic [7:0]  flash_dq_out, flash_dq_in;
  logic        flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n, flash_rst_n, flash_wp_n;

  always #2.5 clk = ~clk;

  pflash_prog_seq #(.WR_HOLD(WRH), .RD_WAIT(RDW), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog),
    .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .done(done), .ok(ok), .fail(fail), .rd_data(rd_data),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n), .flash_rst_n(flash_rst_n), .flash_wp_n(flash_wp_n)
  );

  int checks = 0, errors = 0, cyc = 0;

  // device model and bus log
  int         busy_reads = 0;
  logic [7:0] busy_val = '0, final_val = '0;
  logic [21:0] w_addr [0:63];
  logic [7:0]  w_data [0:63];
  int          w_width [0:63];
  logic [21:0] r_addr_last;
  int n_wr = 0, n_rd = 0, ce_falls = 0, done_cnt = 0, bad_ctl = 0;
  int wlow = 0, rlow = 0, r_width_last = 0;
  logic [21:0] cur_a;
  logic [7:0]  cur_d;
  logic        ce_prev = 1'b1;

  assign flash_dq_in = (n_rd < busy_reads) ? busy_val : final_val;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ce_prev <= flash_ce_n;
    if (ce_prev && !flash_ce_n) ce_falls <= ce_falls + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (!flash_we_n) begin
      wlow <= wlow + 1;
      cur_a <= flash_addr;
      cur_d <= flash_dq_out;
      if (!flash_oe_n || !flash_dq_oe || flash_ce_n) bad_ctl <= bad_ctl + 1;
    end else if (wlow > 0) begin
      if (n_wr < 64) begin
        w_addr[n_wr] <= cur_a; w_data[n_wr] <= cur_d; w_width[n_wr] <= wlow;
      end
      n_wr <= n_wr + 1;
      wlow <= 0;
    end
    if (!flash_oe_n) begin
      rlow <= rlow + 1;
      r_addr_last <= flash_addr;
      if (flash_dq_oe || flash_ce_n) bad_ctl <= bad_ctl + 1;
    end else if (rlow > 0) begin
      n_rd <= n_rd + 1;
      r_width_last <= rlow;
      rlow <= 0;
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    n_wr = 0; n_rd = 0; ce_falls = 0; done_cnt = 0; bad_ctl = 0;
  endtask

  task automatic launch(input bit prog, input logic [21:0] a, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; op_prog = prog; req_addr = a; req_data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, "R8", "done seen", done, 1);
  endtask

  task automatic t_reset();
    chk(flash_ce_n && flash_oe_n && flash_we_n, "R1", "ctl high",
        {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    chk(!flash_dq_oe, "R1", "dq released", flash_dq_oe, 0);
    chk(!busy && !done && !ok && !fail, "R1", "status low", {busy, done, ok, fail}, 0);
    chk(flash_rst_n && flash_wp_n, "R10", "rst/wp high", {flash_rst_n, flash_wp_n}, 2'b11);
  endtask

  task automatic t_read(input logic [21:0] a, input logic [7:0] v);
    clear_log();
    busy_reads = 0; final_val = v;
    launch(1'b0, a, 8'h00);
    wait_done();
    chk(ok && !fail, "R2", "read ok", {ok, fail}, 2'b10);
    chk(rd_data == v, "R2", "rd_data", rd_data, v);
    @(negedge clk);
    chk(n_rd == 1 && n_wr == 0, "R2", "one read cycle", n_rd * 16 + n_wr, 16);
    chk(r_width_last == RDW, "R2", "oe width", r_width_last, RDW);
    chk(r_addr_last == a, "R2", "read address", r_addr_last, a);
    chk(bad_ctl == 0, "R2", "read controls", bad_ctl, 0);
  endtask

  task automatic check_unlock(input logic [21:0] a, input logic [7:0] d);
    chk(w_addr[0] == 22'hAAA && w_data[0] == 8'hAA, "R4", "unlock 1",
        {w_addr[0], w_data[0]}, {22'hAAA, 8'hAA});
    chk(w_addr[1] == 22'h555 && w_data[1] == 8'h55, "R4", "unlock 2",
        {w_addr[1], w_data[1]}, {22'h555, 8'h55});
    chk(w_addr[2] == 22'hAAA && w_data[2] == 8'hA0, "R4", "program cmd",
        {w_addr[2], w_data[2]}, {22'hAAA, 8'hA0});
    chk(w_addr[3] == a && w_data[3] == d, "R4", "data write",
        {w_addr[3], w_data[3]}, {a, d});
    for (int i = 0; i < 4; i++)
      chk(w_width[i] == WRH, "R3", "we width", w_width[i], WRH);
  endtask

  task automatic t_prog_ok(input logic [21:0] a, input logic [7:0] d, input int nb);
    clear_log();
    busy_reads = nb; busy_val = d ^ 8'h80; final_val = d;
    launch(1'b1, a, d);
    wait_done();
    chk(busy, "R8", "busy at done", busy, 1);
    chk(ok && !fail, "R5", "program ok", {ok, fail}, 2'b10);
    @(negedge clk);
    chk(!busy && !done, "R8", "idle after done", {busy, done}, 0);
    repeat (10) @(negedge clk);
    chk(n_wr == 4, "R5", "write count", n_wr, 4);
    chk(n_rd == nb + 1, "R5", "poll reads", n_rd, nb + 1);
    chk(r_addr_last == a, "R5", "poll address", r_addr_last, a);
    chk(ce_falls == n_wr + n_rd, "R11", "ce edges", ce_falls, n_wr + n_rd);
    chk(bad_ctl == 0, "R3", "bus controls", bad_ctl, 0);
    chk(done_cnt == 1, "R8", "single done", done_cnt, 1);
    check_unlock(a, d);
  endtask

  task automatic t_prog_bit5(input logic [21:0] a, input logic [7:0] d);
    clear_log();
    busy_reads = 1000; busy_val = ((~d) & 8'h80) | 8'h20 | (d & 8'h1F); final_val = d;
    launch(1'b1, a, d);
    wait_done();
    chk(fail && !ok, "R6", "fail flag", {ok, fail}, 2'b01);
    @(negedge clk);
    chk(n_rd == 1, "R6", "one poll", n_rd, 1);
    chk(n_wr == 5, "R6", "write count", n_wr, 5);
    chk(w_data[4] == 8'hF0 && w_addr[4] == a, "R6", "reset write",
        {w_addr[4], w_data[4]}, {a, 8'hF0});
    chk(w_width[4] == WRH, "R3", "reset we width", w_width[4], WRH);
  endtask

  task automatic t_timeout(input logic [21:0] a, input logic [7:0] d);
    clear_log();
    busy_reads = 100000; busy_val = (d ^ 8'h80) & 8'hDF; final_val = d;
    launch(1'b1, a, d);
    wait_done();
    chk(fail && !ok, "R7", "fail flag", {ok, fail}, 2'b01);
    @(negedge clk);
    chk(n_rd >= PLIM / (RDW + 2) - 2 && n_rd <= PLIM / (RDW + 2) + 2,
        "R7", "poll count", n_rd, PLIM / (RDW + 2));
    chk(n_wr == 5 && w_data[4] == 8'hF0, "R7", "reset write", w_data[4], 8'hF0);
    chk(done_cnt == 1, "R7", "single done", done_cnt, 1);
  endtask

  task automatic t_busy_ignore(input logic [21:0] a, input logic [7:0] d);
    clear_log();
    busy_reads = 3; busy_val = d ^ 8'h80; final_val = d;
    launch(1'b1, a, d);
    repeat (12) @(negedge clk);
    start = 1'b1; op_prog = 1'b0; req_addr = 22'h3FFFFF;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(ok, "R9", "first op ok", ok, 1);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R9", "no extra done", done_cnt, 1);
    chk(n_wr == 4 && n_rd == 4, "R9", "no extra cycle", n_wr * 16 + n_rd, 68);
    chk(w_addr[3] == a, "R9", "target kept", w_addr[3], a);
    chk(!busy, "R9", "idle after", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(22'h05FF0A, 8'h42);
    t_read(22'h3FFFFF, 8'hA5);
    t_prog_ok(22'h000123, 8'h3C, 0);
    t_prog_ok(22'h2ABCDE, 8'hC7, 5);
    t_prog_bit5(22'h001000, 8'h81);
    t_timeout(22'h0000FF, 8'h00);
    t_busy_ignore(22'h12345, 8'h99);
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule